// File: doc/BRIEF.md
# Predicate Register Store Unit

This unit carries out one store of a predicate register into the local scratchpad memory. A request brings the predicate value, a base pointer with its address-space tag, a signed slot offset, a layout code and an element-size code. The unit forms the target address as the base plus eight times the offset. It checks the address space, the alignment and the layout code. It then shapes the 64-bit word and issues it as one full-width write on a plain memory write port. A request that fails a check produces an error code instead, and the memory sees no write at all.

The unit is built around a three-state controller. `ST_IDLE` holds the request port ready. An accepted request goes to `ST_WRITE` when every check passes (transition *accept-ok*). It goes to `ST_FAULT` when a check fails (transition *accept-bad*). Both of those states last exactly one cycle and return to `ST_IDLE` (transitions *write-done* and *fault-done*). A new request can therefore be taken every second cycle.

Top module: `pred_store_unit`

## Requirements
- R1: `req_ready` is high only in `ST_IDLE`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the following cycle `req_ready` is low, and the cycle after that it is high again.
- R2: The write address is `req_base + sext(req_offset) * 8`, computed in 32 bits. It appears on `mem_addr` together with `mem_we` in the cycle right after acceptance.
- R3: A legal request produces exactly one cycle of `mem_we`, with all eight bits of `mem_be` set. `mem_we` is never high on two cycles in a row.
- R4: A `req_space` value other than 1 (the scratchpad tag) gives `err_code` 1 with `err_valid` in the cycle after acceptance, and no write.
- R5: A target address whose low three bits are not zero gives `err_code` 2, and no write.
- R6: A `req_mode` of 2 or 3 is illegal. It gives `err_code` 3, and no write. Mode 0 is the plain layout and mode 1 is the packed layout.
- R7: When several checks fail, the code reported is the address-space code first, then the alignment code, then the mode code.
- R8: Plain layout (mode 0): `mem_wdata` takes predicate bits [63:0] in place.
- R9: Packed layout (mode 1): `mem_wdata[63:32]` takes predicate bits [95:64] (segment 2), and `mem_wdata[31:0]` takes bits [31:0] (segment 0).
- R10: Element size applies to each 32-bit half of the word on its own. Code 0 (8-bit elements) keeps all 32 bits. Code 1 (16-bit) keeps the low 16 bits. Codes 2 and 3 (32-bit) keep the low 8 bits. Every other bit of the half is written as zero.
- R11: After reset and in every cycle, `mem_we` and `err_valid` are never high together. When `err_valid` is low, `err_code` is 0. A fault holds `err_valid` for one cycle. Reset leaves `req_ready` high and both `mem_we` and `err_valid` low.
- R12: A negative offset moves the address downward. Address arithmetic that passes 2^32 wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_pred | input | 128 | Predicate register, four 32-bit segments |
| req_base | input | 32 | Base byte address |
| req_space | input | 2 | Address-space tag of the base pointer |
| req_offset | input | 32 | Signed offset in 8-byte slots |
| req_mode | input | 2 | Layout code (0 plain, 1 packed) |
| req_esize | input | 2 | Element-size code |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_be | output | 8 | Byte enables |
| err_valid | output | 1 | Fault reported this cycle |
| err_code | output | 2 | Fault code (0 none, 1 space, 2 alignment, 3 mode) |

## Verification
The bench builds the unit with its default parameters. These are a 128-bit predicate, 32-bit segments and addresses, a 64-bit word and a scratchpad tag of 1. With these values every field position named in the requirements is a fixed bit range that the reference model can compute on its own. These widths also bring a few cases within reach of short directed stimulus: a base near the top of the 32-bit space, so the address wraps, and offsets with the sign bit set. Exact ties between the three checks can likewise be reached with a handful of requests. A stream of random requests then mixes all the codes with back-to-back traffic.

// File: rtl/pstore_pkg.sv
package pstore_pkg;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SPACE = 2'd1,
        ERR_ALIGN = 2'd2,
        ERR_MODE  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_PACK  = 2'd1
    } layout_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } state_e;

endpackage

// File: rtl/pstore_addr.sv
module pstore_addr
    import pstore_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 32,
    parameter int WORD_BYTES = 8,
    parameter int SPACE_W    = 2,
    parameter logic [SPACE_W-1:0] LOCAL_SPACE = 1
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [SPACE_W-1:0] space,
    input  logic [OFF_W-1:0]   offset,
    input  logic [1:0]         mode,
    output logic [ADDR_W-1:0]  eff_addr,
    output err_e               err
);

    localparam int SHIFT = $clog2(WORD_BYTES);

    logic [ADDR_W-1:0] off_ext;
    logic              misaligned;
    logic              mode_ok;

    generate
        if (ADDR_W > OFF_W) begin : g_extend
            assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign eff_addr   = base + (off_ext << SHIFT);
    assign misaligned = |eff_addr[SHIFT-1:0];
    assign mode_ok    = (mode == MODE_PLAIN) || (mode == MODE_PACK);

    always_comb begin
        if (space != LOCAL_SPACE) begin
            err = ERR_SPACE;
        end else if (misaligned) begin
            err = ERR_ALIGN;
        end else if (!mode_ok) begin
            err = ERR_MODE;
        end else begin
            err = ERR_NONE;
        end
    end

endmodule

// File: rtl/pstore_fmt.sv
module pstore_fmt #(
    parameter int PRED_W = 128,
    parameter int SEG_W  = 32,
    parameter int WORD_W = 64
) (
    input  logic [PRED_W-1:0] pred,
    input  logic              pack,
    input  logic [1:0]        esize,
    output logic [WORD_W-1:0] word
);

    localparam int HALVES = WORD_W / SEG_W;
    localparam int IDX_W  = $clog2(SEG_W + 1);
    localparam int TOP_USED = (2 * HALVES - 1) * SEG_W;

    logic [IDX_W-1:0] keep;
    logic [SEG_W-1:0] lane_mask;
    logic             unused_hi;

    assign unused_hi = ^pred[PRED_W-1:TOP_USED];

    always_comb begin
        case (esize)
            2'd0:    keep = IDX_W'(SEG_W);
            2'd1:    keep = IDX_W'(SEG_W / 2);
            default: keep = IDX_W'(SEG_W / 4);
        endcase
    end

    always_comb begin
        for (int j = 0; j < SEG_W; j++) begin
            lane_mask[j] = (IDX_W'(j) < keep);
        end
    end

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            logic [SEG_W-1:0] seg_plain;
            logic [SEG_W-1:0] seg_pack;
            assign seg_plain = pred[h*SEG_W +: SEG_W];
            assign seg_pack  = pred[2*h*SEG_W +: SEG_W];
            assign word[h*SEG_W +: SEG_W] = (pack ? seg_pack : seg_plain) & lane_mask;
        end
    endgenerate

endmodule

// File: rtl/pred_store_unit.sv
module pred_store_unit
    import pstore_pkg::*;
#(
    parameter int PRED_W  = 128,
    parameter int SEG_W   = 32,
    parameter int WORD_W  = 64,
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 32,
    parameter int SPACE_W = 2,
    parameter logic [SPACE_W-1:0] LOCAL_SPACE = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [PRED_W-1:0]   req_pred,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [SPACE_W-1:0]  req_space,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [1:0]          req_mode,
    input  logic [1:0]          req_esize,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [WORD_W/8-1:0] mem_be,
    output logic                err_valid,
    output logic [1:0]          err_code
);

    localparam int BE_W  = WORD_W / 8;
    localparam int SHIFT = $clog2(BE_W);

    state_e            state, state_nx;
    logic              take;
    logic [ADDR_W-1:0] calc_addr;
    err_e              calc_err;
    logic [WORD_W-1:0] calc_word;
    logic [ADDR_W-1:0] hold_addr;
    logic [WORD_W-1:0] hold_word;
    err_e              hold_err;

    pstore_addr #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WORD_BYTES(BE_W),
        .SPACE_W(SPACE_W), .LOCAL_SPACE(LOCAL_SPACE)
    ) u_addr (
        .base(req_base), .space(req_space), .offset(req_offset),
        .mode(req_mode), .eff_addr(calc_addr), .err(calc_err)
    );

    pstore_fmt #(
        .PRED_W(PRED_W), .SEG_W(SEG_W), .WORD_W(WORD_W)
    ) u_fmt (
        .pred(req_pred), .pack(req_mode == MODE_PACK),
        .esize(req_esize), .word(calc_word)
    );

    assign take = req_valid && (state == ST_IDLE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = (calc_err == ERR_NONE) ? ST_WRITE : ST_FAULT;
                end
            end
            ST_WRITE: state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_word <= '0;
            hold_err  <= ERR_NONE;
        end else if (take) begin
            hold_addr <= calc_addr;
            hold_word <= calc_word;
            hold_err  <= calc_err;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        err_valid = 1'b0;
        err_code  = ERR_NONE;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_WRITE: begin
                mem_we    = 1'b1;
                mem_addr  = hold_addr;
                mem_wdata = hold_word;
                mem_be    = '1;
            end
            ST_FAULT: begin
                err_valid = 1'b1;
                err_code  = hold_err;
            end
            default: req_ready = 1'b0;
        endcase
    end

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    we_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[SHIFT-1:0] == '0));

    // R3
    be_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (&mem_be));

    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    space_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_space != LOCAL_SPACE)
            |=> (err_valid && err_code == 2'd1 && !mem_we));

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && err_valid));

    // R11
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> (err_code == 2'd0));

endmodule

// File: tb/sim_pred_store_unit.sv
module sim_pred_store_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [127:0] req_pred = '0;
    logic [31:0]  req_base = '0;
    logic [1:0]   req_space = '0;
    logic [31:0]  req_offset = '0;
    logic [1:0]   req_mode = '0;
    logic [1:0]   req_esize = '0;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata;
    logic [7:0]   mem_be;
    logic         err_valid;
    logic [1:0]   err_code;

    int checks = 0;
    int errors = 0;

    pred_store_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pred(req_pred), .req_base(req_base), .req_space(req_space),
        .req_offset(req_offset), .req_mode(req_mode), .req_esize(req_esize),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .err_valid(err_valid), .err_code(err_code)
    );

    always #4 clk = ~clk;

    // reference model state
    bit          m_busy = 0;
    bit          m_we = 0;
    bit          m_errv = 0;
    logic [1:0]  m_code = 0;
    logic [31:0] m_addr = 0;
    logic [63:0] m_word = 0;
    string       m_atag = "R2";
    string       m_dtag = "R8";
    string       m_etag = "R4";

    function automatic logic [31:0] ref_addr(input logic [31:0] b, input logic [31:0] o);
        longint a;
        a = longint'(b) + longint'($signed(o)) * 8;
        return a[31:0];
    endfunction

    function automatic logic [63:0] ref_word(input logic [127:0] p,
                                             input logic [1:0] md,
                                             input logic [1:0] es);
        logic [63:0] w;
        int keep;
        keep = (es == 0) ? 32 : (es == 1) ? 16 : 8;
        w = '0;
        for (int h = 0; h < 2; h++) begin
            int seg;
            seg = (md == 1) ? 2 * h : h;
            for (int j = 0; j < keep; j++) w[h*32 + j] = p[seg*32 + j];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_we = 0; m_errv = 0; m_code = 0;
        end else if (m_busy) begin
            m_busy = 0; m_we = 0; m_errv = 0; m_code = 0;
        end else if (req_valid) begin
            logic [31:0] a;
            int nfail;
            longint raw;
            a = ref_addr(req_base, req_offset);
            raw = longint'(req_base) + longint'($signed(req_offset)) * 8;
            nfail = int'(req_space != 1) + int'(a[2:0] != 0) + int'(req_mode > 1);
            m_busy = 1;
            if (req_space != 1) m_code = 1;
            else if (a[2:0] != 0) m_code = 2;
            else if (req_mode > 1) m_code = 3;
            else m_code = 0;
            m_etag = (nfail > 1) ? "R7" : (m_code == 1) ? "R4" : (m_code == 2) ? "R5" : "R6";
            m_atag = (req_offset[31] || raw > 64'hFFFF_FFFF) ? "R12" : "R2";
            m_dtag = (req_esize != 0) ? "R10" : (req_mode == 1) ? "R9" : "R8";
            m_we   = (m_code == 0);
            m_errv = (m_code != 0);
            m_addr = a;
            m_word = ref_word(req_pred, req_mode, req_esize);
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 ready", 64'(req_ready), 64'(!m_busy));
            check("R3 we", 64'(mem_we), 64'(m_we));
            check("R11 err_valid", 64'(err_valid), 64'(m_errv));
            if (m_errv) check({m_etag, " code"}, 64'(err_code), 64'(m_code));
            else check("R11 idle code", 64'(err_code), 64'd0);
            if (m_we) begin
                check({m_atag, " addr"}, 64'(mem_addr), 64'(m_addr));
                check({m_dtag, " data"}, mem_wdata, m_word);
                check("R3 be", 64'(mem_be), 64'hFF);
            end
        end
    end

    task automatic send(input logic [127:0] p, input logic [31:0] b, input logic [1:0] sp,
                        input logic [31:0] o, input logic [1:0] md, input logic [1:0] es);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_pred = p; req_base = b; req_space = sp;
        req_offset = o; req_mode = md; req_esize = es;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    localparam logic [127:0] PAT = 128'hDDDD_0003_CCCC_0002_BBBB_0001_A5C3_F00F;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset ready", 64'(req_ready), 64'd1);
        check("R11 reset we", 64'(mem_we), 64'd0);
        check("R11 reset err", 64'(err_valid), 64'd0);
        rst_n = 1;
        send(PAT, 32'h0000_1000, 1, 32'd5, 0, 0);           // R2 R8
        send(PAT, 32'h0000_0100, 1, -32'sd4, 0, 0);         // R12 negative
        send(PAT, 32'hFFFF_FFF8, 1, 32'd2, 0, 0);           // R12 wrap
        send(PAT, 32'h0000_2000, 1, 32'd0, 1, 0);           // R9 packed
        for (int es = 1; es < 4; es++) begin                // R10
            send(PAT, 32'h40, 1, 32'd1, 0, 2'(es));
            send(PAT, 32'h40, 1, 32'd1, 1, 2'(es));
        end
        for (int sp = 0; sp < 4; sp++) if (sp != 1) send(PAT, 32'h80, 2'(sp), 0, 0, 0); // R4
        send(PAT, 32'h0000_1003, 1, 32'd1, 0, 0);           // R5
        send(PAT, 32'h0000_1004, 1, 32'd1, 1, 0);           // R5
        send(PAT, 32'h0000_1000, 1, 32'd1, 2, 0);           // R6
        send(PAT, 32'h0000_1000, 1, 32'd1, 3, 0);           // R6
        send(PAT, 32'h0000_1001, 0, 32'd1, 3, 0);           // R7 space wins
        send(PAT, 32'h0000_1001, 1, 32'd1, 2, 0);           // R7 align beats mode
        for (int n = 0; n < 400; n++) begin                 // R1 back to back, mixed
            logic [31:0] b;
            b = $urandom;
            if ($urandom % 4 != 0) b[2:0] = 0;
            send({$urandom, $urandom, $urandom, $urandom}, b,
                 ($urandom % 5 == 0) ? 2'($urandom) : 2'd1,
                 $urandom, ($urandom % 6 == 0) ? 2'($urandom) : 2'($urandom % 2),
                 2'($urandom));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule